// File: doc/BRIEF.md
# Simultaneous-Sampling Conversion Sequencer

This block is the digital control side of a multi-channel converter whose channels are all sampled together and then converted one after another. Every action happens on the rising edge of the converter clock. A host writes a channel-enable byte over a small parallel port. It then drives an active-low start strobe. While the strobe is low, the channels acquire. When the strobe returns high, conversion begins.

The first result is ready after a long fixed latency. Each following result comes after a short fixed spacing. Enabled channels are handled in ascending index order, and a disabled channel takes no clock cycles. For every result the block emits a one-cycle end-of-conversion pulse. It also reports the channel number and the result word, and writes the word into a result register file that can be read at any time. A frame-busy flag covers the whole frame, from acquisition through the last result. The result words come from a stub source, which stands in for the analog converter.

Top module: `simsamp_seq`

## Requirements
- R1: The enable mask takes `bus_din` on a rising clock edge where `bus_sel_n` and `bus_wr_n` are both low. A strobe with only one of the two low leaves the mask unchanged. Bit i of the mask enables channel i.
- R2: `frame_busy` goes high at the first clock edge that samples `conv_start_n` low after it was high, and it stays high throughout acquisition.
- R3: The clock edge that first samples `conv_start_n` high again is the conversion-start edge. The first `eoc` pulse begins 12 edges after it.
- R4: Each later `eoc` pulse begins 3 edges after the previous one. Channels are served in ascending index order, and disabled channels are skipped with no added cycles.
- R5: `eoc` is high for exactly one cycle per result. While it is high, `eoc_chan` holds the channel index and `eoc_data` holds the stub value. The stub value is the 9-bit frame number in bits 11:3 and the channel index in bits 2:0. The frame number starts at 0 and increments, modulo 512, at the end of each frame.
- R6: `frame_busy` falls at the same edge that raises the `eoc` pulse of the last enabled channel.
- R7: With an all-zero mask, `frame_busy` falls 12 edges after the conversion-start edge, and no `eoc` pulse occurs.
- R8: Edges on `conv_start_n` while a frame is running, other than the one that starts conversion, are ignored. They are not remembered once the frame ends.
- R9: The mask is captured when acquisition starts. A mask write during a frame affects only later frames.
- R10: Each result is written into entry `eoc_chan` of the result file at the edge that raises `eoc`. Entries of skipped channels keep their previous values. `rd_data` is a combinational read of entry `rd_sel`.
- R11: After reset, `frame_busy` and `eoc` are low, the mask is zero and every result entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start_n | input | 1 | Start strobe: low acquires, rising starts conversion |
| bus_sel_n | input | 1 | Parallel port select, active low |
| bus_wr_n | input | 1 | Parallel port write, active low |
| bus_din | input | 8 | Channel-enable byte |
| eoc | output | 1 | One-cycle pulse per completed channel |
| eoc_chan | output | 3 | Channel index of the current result |
| eoc_data | output | 12 | Result word of the current result |
| frame_busy | output | 1 | High from acquisition start until the last result |
| rd_sel | input | 3 | Result file read index |
| rd_data | output | 12 | Result file read data |

## Verification
The bench targets several timing and masking corner cases.

- It checks the exact cycle of the first result and of every later result. A design with an off-by-one counter reload would shift every pulse, and the scoreboard would reject the timestamps.
- It uses sparse masks, a single high channel and an empty mask. A sequencer that spent cycles on disabled channels, or that hung or pulsed on an empty frame, would show a wrong result time or an unexpected pulse.
- It pulses the start strobe in the middle of a frame and writes the mask in the middle of a frame. A design that restarted the frame, queued the stray edge or used the live mask would produce extra frames or wrong channels.
- It drives half-asserted write strobes. A design that latched on either strobe alone would load the wrong mask.

// File: rtl/simsamp_pkg.sv
package simsamp_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_ACQ  = 2'd1,
      SEQ_CONV = 2'd2
   } seq_state_t;
endpackage

// File: rtl/strobe_edge.sv
// Registers the previous level of an active-low strobe and flags its edges.
module strobe_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_n,
   output logic fell,
   output logic rose
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= lvl_n;
   end

   assign fell = prev_q & ~lvl_n;
   assign rose = ~prev_q & lvl_n;
endmodule

// File: rtl/mask_port.sv
// Write port for the channel-enable mask; select and write combine by AND.
module mask_port #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sel_n,
   input  logic         wr_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] mask_q
);
   logic strobe;
   assign strobe = ~sel_n & ~wr_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask_q <= '0;
      else if (strobe) mask_q <= din;
   end
endmodule

// File: rtl/low_pick.sv
// Finds the lowest set bit of a request vector.
module low_pick #(
   parameter int N   = 8,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  req,
   output logic          found,
   output logic [IW-1:0] idx,
   output logic [N-1:0]  onehot
);
   generate
      if (N == 1) begin : g_single
         assign found  = req[0];
         assign idx    = '0;
         assign onehot = req;
      end else begin : g_multi
         always_comb begin
            found  = 1'b0;
            idx    = '0;
            onehot = '0;
            for (int i = N - 1; i >= 0; i--) begin
               if (req[i]) begin
                  found  = 1'b1;
                  idx    = IW'(i);
                  onehot = '0;
                  onehot[i] = 1'b1;
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/result_file.sv
// One register per channel holding the most recent result.
module result_file #(
   parameter int N   = 8,
   parameter int DW  = 12,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [IW-1:0] widx,
   input  logic [DW-1:0] wdata,
   input  logic [IW-1:0] rsel,
   output logic [DW-1:0] rdata
);
   logic [DW-1:0] ent [N];

   generate
      for (genvar g = 0; g < N; g++) begin : g_ent
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                             ent[g] <= '0;
            else if (we && (widx == IW'(g)))        ent[g] <= wdata;
         end
      end
   endgenerate

   assign rdata = (int'(rsel) < N) ? ent[rsel] : '0;
endmodule

// File: rtl/simsamp_seq.sv
module simsamp_seq #(
   parameter int CH_N      = 8,
   parameter int DATA_W    = 12,
   parameter int FIRST_LAT = 12,
   parameter int NEXT_LAT  = 3,
   localparam int IDX_W    = (CH_N > 1) ? $clog2(CH_N) : 1,
   localparam int FRM_W    = DATA_W - IDX_W,
   localparam int CNT_W    = $clog2(FIRST_LAT + NEXT_LAT) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              conv_start_n,
   input  logic              bus_sel_n,
   input  logic              bus_wr_n,
   input  logic [CH_N-1:0]   bus_din,
   output logic              eoc,
   output logic [IDX_W-1:0]  eoc_chan,
   output logic [DATA_W-1:0] eoc_data,
   output logic              frame_busy,
   input  logic [IDX_W-1:0]  rd_sel,
   output logic [DATA_W-1:0] rd_data
);
   import simsamp_pkg::*;

   generate
      if (FIRST_LAT < 2)      begin : g_bad_first $error("FIRST_LAT must be at least 2"); end
      if (NEXT_LAT < 2)       begin : g_bad_next  $error("NEXT_LAT must be at least 2"); end
      if (FRM_W < 1)          begin : g_bad_dw    $error("DATA_W too narrow for CH_N"); end
   endgenerate

   logic              st_fell, st_rose;
   logic [CH_N-1:0]   mask_q;
   logic [CH_N-1:0]   pend_q;
   logic              pick_found;
   logic [IDX_W-1:0]  pick_idx;
   logic [CH_N-1:0]   pick_oh;
   seq_state_t        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [FRM_W-1:0]  frame_q;
   logic              fire;
   logic [DATA_W-1:0] stub_word;

   strobe_edge u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl_n (conv_start_n),
      .fell  (st_fell),
      .rose  (st_rose)
   );

   mask_port #(.W(CH_N)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_n  (bus_sel_n),
      .wr_n   (bus_wr_n),
      .din    (bus_din),
      .mask_q (mask_q)
   );

   low_pick #(.N(CH_N)) u_pick (
      .req    (pend_q),
      .found  (pick_found),
      .idx    (pick_idx),
      .onehot (pick_oh)
   );

   assign fire      = (state_q == SEQ_CONV) && (cnt_q == '0) && pick_found;
   assign stub_word = {frame_q, pick_idx};

   result_file #(.N(CH_N), .DW(DATA_W)) u_file (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (fire),
      .widx  (pick_idx),
      .wdata (stub_word),
      .rsel  (rd_sel),
      .rdata (rd_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= SEQ_IDLE;
         cnt_q      <= '0;
         pend_q     <= '0;
         frame_q    <= '0;
         frame_busy <= 1'b0;
         eoc        <= 1'b0;
         eoc_chan   <= '0;
         eoc_data   <= '0;
      end else begin
         eoc <= 1'b0;
         unique case (state_q)
            SEQ_IDLE: begin
               if (st_fell) begin
                  state_q    <= SEQ_ACQ;
                  frame_busy <= 1'b1;
                  pend_q     <= mask_q;
               end
            end
            SEQ_ACQ: begin
               if (st_rose) begin
                  state_q <= SEQ_CONV;
                  cnt_q   <= CNT_W'(FIRST_LAT - 1);
               end
            end
            SEQ_CONV: begin
               if (cnt_q != '0) begin
                  cnt_q <= cnt_q - 1'b1;
               end else if (pick_found) begin
                  eoc      <= 1'b1;
                  eoc_chan <= pick_idx;
                  eoc_data <= stub_word;
                  pend_q   <= pend_q & ~pick_oh;
                  if ((pend_q & ~pick_oh) == '0) begin
                     state_q    <= SEQ_IDLE;
                     frame_busy <= 1'b0;
                     frame_q    <= frame_q + 1'b1;
                  end else begin
                     cnt_q <= CNT_W'(NEXT_LAT - 1);
                  end
               end else begin
                  state_q    <= SEQ_IDLE;
                  frame_busy <= 1'b0;
                  frame_q    <= frame_q + 1'b1;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/simsamp_seq_chk.sv
module simsamp_seq_chk #(
   parameter int CH_N     = 8,
   parameter int NEXT_LAT = 3
) (
   input logic            clk,
   input logic            rst_n,
   input logic            conv_start_n,
   input logic            bus_sel_n,
   input logic            bus_wr_n,
   input logic [CH_N-1:0] bus_din,
   input logic [CH_N-1:0] mask_q,
   input logic            eoc,
   input logic            frame_busy
);
   logic [7:0] gap_q;
   logic       seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
      end else begin
         if (eoc) begin
            gap_q  <= 8'd1;
            seen_q <= 1'b1;
         end else begin
            if (gap_q != 8'hFF) gap_q <= gap_q + 1'b1;
            if (!frame_busy) seen_q <= 1'b0;
         end
      end
   end

   // R1
   mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_sel_n && !bus_wr_n) |=> (mask_q == $past(bus_din)));

   // R1
   mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel_n || bus_wr_n) |=> $stable(mask_q));

   // R2
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(frame_busy) |-> ($past(conv_start_n) == 1'b0));

   // R5
   eoc_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eoc |=> !eoc);

   // R6
   eoc_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eoc |-> $past(frame_busy));

   // R4
   eoc_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eoc && seen_q) |-> (gap_q == 8'(NEXT_LAT)));
endmodule

bind simsamp_seq simsamp_seq_chk #(.CH_N(CH_N), .NEXT_LAT(NEXT_LAT)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .conv_start_n (conv_start_n),
   .bus_sel_n    (bus_sel_n),
   .bus_wr_n     (bus_wr_n),
   .bus_din      (bus_din),
   .mask_q       (mask_q),
   .eoc          (eoc),
   .frame_busy   (frame_busy)
);

// File: tb/sim_simsamp_seq.sv
module sim_simsamp_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        conv_start_n = 1'b1;
   logic        bus_sel_n = 1'b1;
   logic        bus_wr_n = 1'b1;
   logic [7:0]  bus_din = '0;
   logic        eoc;
   logic [2:0]  eoc_chan;
   logic [11:0] eoc_data;
   logic        frame_busy;
   logic [2:0]  rd_sel = '0;
   logic [11:0] rd_data;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int frame_no = 0;
   logic [11:0] exp_rf [8];

   typedef struct {
      logic [2:0]  ch;
      logic [11:0] d;
      int          t;
   } exp_item_t;
   exp_item_t sb_q [$];

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   simsamp_seq u0 (
      .clk(clk), .rst_n(rst_n), .conv_start_n(conv_start_n),
      .bus_sel_n(bus_sel_n), .bus_wr_n(bus_wr_n), .bus_din(bus_din),
      .eoc(eoc), .eoc_chan(eoc_chan), .eoc_data(eoc_data),
      .frame_busy(frame_busy), .rd_sel(rd_sel), .rd_data(rd_data)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   // Monitor: pops the scoreboard on every result pulse
   always @(negedge clk) begin
      if (rst_n && eoc) begin
         if (sb_q.size() == 0) begin
            chk(1'b0, "R7 unexpected eoc", int'(eoc_chan), -1);
         end else begin
            exp_item_t e;
            e = sb_q.pop_front();
            chk(eoc_chan == e.ch, "R4 channel order", int'(eoc_chan), int'(e.ch));
            chk(eoc_data == e.d, "R5 result word", int'(eoc_data), int'(e.d));
            chk(cyc == e.t, "R3 result timing", cyc, e.t);
         end
      end
   end

   task automatic write_mask(input logic [7:0] v, input logic sel_n, input logic wr_n);
      @(negedge clk);
      bus_sel_n = sel_n; bus_wr_n = wr_n; bus_din = v;
      @(negedge clk);
      bus_sel_n = 1'b1; bus_wr_n = 1'b1; bus_din = 8'h00;
   endtask

   // Driver: runs one frame and pushes the expected results
   task automatic run_frame(input logic [7:0] m, input int acq, input bit glitch,
                            input bit midwr, input logic [7:0] mw);
      int t0, k, tend;
      @(negedge clk);
      conv_start_n = 1'b0;
      repeat (acq) @(negedge clk);
      chk(frame_busy == 1'b1, "R2 busy in acquisition", int'(frame_busy), 1);
      conv_start_n = 1'b1;
      t0 = cyc;
      k = 0;
      for (int c = 0; c < 8; c++) begin
         if (m[c]) begin
            exp_item_t e;
            e.ch = 3'(c);
            e.d  = {9'(frame_no), 3'(c)};
            e.t  = t0 + 13 + 3 * k;
            sb_q.push_back(e);
            exp_rf[c] = e.d;
            k++;
         end
      end
      tend = (k == 0) ? t0 + 13 : t0 + 13 + 3 * (k - 1);
      if (glitch) begin
         repeat (4) @(negedge clk);
         conv_start_n = 1'b0;
         repeat (2) @(negedge clk);
         conv_start_n = 1'b1;
      end
      if (midwr) write_mask(mw, 1'b0, 1'b0);
      while (cyc < tend - 1) @(negedge clk);
      chk(frame_busy == 1'b1, "R6 busy before last", int'(frame_busy), 1);
      @(negedge clk);
      chk(frame_busy == 1'b0, (k == 0) ? "R7 empty frame end" : "R6 busy falls", int'(frame_busy), 0);
      repeat (4) @(negedge clk);
      chk(frame_busy == 1'b0, "R8 stray edge not queued", int'(frame_busy), 0);
      chk(sb_q.size() == 0, "R4 all results seen", sb_q.size(), 0);
      frame_no++;
   endtask

   task automatic check_file(input string req);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         rd_sel = 3'(i);
         #1;
         chk(rd_data == exp_rf[i], req, int'(rd_data), int'(exp_rf[i]));
      end
   endtask

   initial begin
      for (int i = 0; i < 8; i++) exp_rf[i] = '0;
      repeat (3) @(negedge clk);
      chk(frame_busy == 1'b0, "R11 reset busy", int'(frame_busy), 0);
      chk(eoc == 1'b0, "R11 reset eoc", int'(eoc), 0);
      rst_n = 1'b1;
      check_file("R11 reset file");

      write_mask(8'hFF, 1'b0, 1'b0);
      run_frame(8'hFF, 3, 1'b0, 1'b0, 8'h00);
      write_mask(8'hA5, 1'b0, 1'b0);
      run_frame(8'hA5, 5, 1'b0, 1'b0, 8'h00);
      check_file("R10 skipped entries kept");
      write_mask(8'h00, 1'b0, 1'b0);
      run_frame(8'h00, 2, 1'b0, 1'b0, 8'h00);
      write_mask(8'h80, 1'b0, 1'b0);
      run_frame(8'h80, 1, 1'b0, 1'b0, 8'h00);
      write_mask(8'h01, 1'b0, 1'b0);
      write_mask(8'hFF, 1'b1, 1'b0);   // R1: select high, ignored
      write_mask(8'hFE, 1'b0, 1'b1);   // R1: write high, ignored
      run_frame(8'h01, 4, 1'b1, 1'b0, 8'h00);   // R1 mask kept, R8 glitch
      write_mask(8'h3C, 1'b0, 1'b0);
      run_frame(8'h3C, 2, 1'b1, 1'b1, 8'h03);   // R9 old mask used
      run_frame(8'h03, 2, 1'b0, 1'b0, 8'h00);   // R9 new mask next frame
      check_file("R10 file contents");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule